// File: doc/BRIEF.md
# Power Fault Flag Response Controller

This block decides how a three-channel digitally controlled power converter reacts to its protection flags. Each cycle it captures a set of raw fault conditions into flag bits. It hides selected flags from the protective logic while the channel they belong to is ramping up in soft start. It filters the supply overvoltage condition through a selectable debounce time. From the external fault input and the supply overvoltage flag it works out which PWM channels (A, B, C) must be switched off.

When the cause of a shutdown goes away, the outputs come back in one of three ways. They can return through soft start after a programmable delay. They can return at once with no ramp. Or they can stay off until the power-on request input shows a rising edge. The block drives a per-channel PWM-disable level and a one-cycle soft-start request strobe toward the PWM generator and the soft-start ramp, which sit outside it.

All times are counted in ticks of a single-cycle 1 µs timebase input. The delay bases are parameters, so that short values can be used in test.

Top module: `fault_flag_ctrl`

## Requirements
- R1: While reset is asserted, `pwm_off`, `ss_req` and `flag_set` are all zero.
- R2: `flag_set[14:0]` equals `raw_flags` one clock later, whether or not the flag is masked. Index map: 0 external fault, 1 temperature 1, 2 temperature 2, 3 AC sense, 4/5 reverse current A/B, 6/7 undervoltage A/B, 8/9 primary current A/B, 10/11 secondary current A/B, 12/13 output overvoltage A/B, 14 channel C current. `flag_set[15]` is the debounced supply overvoltage flag. `flag_act` is `flag_set` with the masked bits cleared.
- R3: While any bit of `ss_busy` (bit 0 = A, 1 = B, 2 = C) is set, flags 0 to 3 are masked.
- R4: Reverse current and undervoltage of channel A (flags 4 and 6) are masked while channel A is in soft start. The channel B pair (flags 5 and 7) is masked while channel B is in soft start.
- R5: Bit i of `cfg_ss_nomask` controls flag 8+i during the soft start of its channel (A for i = 0, 2, 4; B for i = 1, 3, 5; C for i = 6). A value of 0 masks the flag; a value of 1 never masks it. Flag 15 is never masked.
- R6: While flag 0 is active, `cfg_ext_action` selects the channels to disable: 00 none, 01 A, 10 B, 11 all three. The disable shows on `pwm_off` two clocks after the raw input rises.
- R7: The supply overvoltage flag sets after the raw condition has been present for `DEB_LONG` ticks (`cfg_vov_fast`=0) or `DEB_SHORT` ticks (`cfg_vov_fast`=1). The count restarts if the condition drops early. The flag clears one clock after the condition goes away.
- R8: While `cfg_vov_ignore` is 1, the supply overvoltage flag stays clear.
- R9: An active supply overvoltage flag disables all three channels. After it clears, they restart through soft start after the re-enable delay.
- R10: The re-enable delay is `DLY_BASE` ticks times 1, 2, 4 or 8 for `cfg_reen_dly` = 00, 01, 10, 11. Once the fault clears, `pwm_off` drops and `ss_req` pulses for one cycle with the disabled channels, delay+2 clocks after the raw clear. Cycles without a tick do not count.
- R11: With `cfg_ext_after`=01, the disabled channels return two clocks after the external fault clears, and `ss_req` stays zero.
- R12: With `cfg_ext_after`=10 or 11, the channels stay off after the clear until a rising edge on `pson`. One clock after that edge, `pwm_off` drops and `ss_req` pulses the restored channels.
- R13: A `pson` rising edge while the block waits out the re-enable delay has no effect.
- R14: A new fault during the re-enable delay aborts it, and the full delay restarts once that fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle 1 µs timebase pulse |
| raw_flags | input | 15 | Raw fault conditions, index map in R2 |
| vdd_ov_raw | input | 1 | Raw supply overvoltage condition |
| ss_busy | input | 3 | Channel in soft start (bit 0 A, 1 B, 2 C) |
| pson | input | 1 | Power-on request |
| cfg_ss_nomask | input | 7 | Per-flag soft-start mask disable (R5) |
| cfg_reen_dly | input | 2 | Re-enable delay select |
| cfg_vov_ignore | input | 1 | Hold the supply overvoltage flag clear |
| cfg_vov_fast | input | 1 | Select the short overvoltage debounce |
| cfg_ext_action | input | 2 | Channels disabled by the external fault |
| cfg_ext_after | input | 2 | Restart policy after the external fault clears |
| flag_set | output | 16 | Flag state, masked or not |
| flag_act | output | 16 | Flags that are set and not masked |
| pwm_off | output | 3 | Per-channel PWM disable |
| ss_req | output | 3 | One-cycle soft-start request per channel |

## Verification
The bench builds the block with `DLY_BASE`=20, `DEB_LONG`=10 and `DEB_SHORT`=3, and keeps `tick_us` high except in one gating test. These values make every debounce and delay boundary reachable in a few tens of cycles. The bench can sample the cycle before and the cycle of each transition for all four delay codes, debounce restarts, aborted delays and the PSON wait. A table of masking vectors covers each soft-start combination against the nomask bits.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    localparam int NUM_CH    = 3;
    localparam int NUM_RAW   = 15;
    localparam int NUM_FLAGS = NUM_RAW + 1;
    localparam int NUM_CFGM  = 7;

    // flag index map
    localparam int FI_EXT   = 0;
    localparam int FI_OT1   = 1;
    localparam int FI_OT2   = 2;
    localparam int FI_ACS   = 3;
    localparam int FI_REV_A = 4;
    localparam int FI_REV_B = 5;
    localparam int FI_UV_A  = 6;
    localparam int FI_UV_B  = 7;
    localparam int FI_CFG0  = 8;
    localparam int FI_VDD   = 15;

    typedef enum logic [1:0] {
        POL_NOW   = 2'd0,
        POL_DELAY = 2'd1,
        POL_PSON  = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FAULT,
        ST_WAIT_DLY,
        ST_WAIT_PSON
    } seq_st_e;

    function automatic pol_e pol_max(pol_e a, pol_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ffc_ovp_deb.sv
module ffc_ovp_deb #(
    parameter int DEB_LONG  = 500,
    parameter int DEB_SHORT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic ignore,
    input  logic fast,
    output logic flag
);
    localparam int DEB_MAX = (DEB_LONG > DEB_SHORT) ? DEB_LONG : DEB_SHORT;
    localparam int CW      = $clog2(DEB_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flg;
    } deb_t;

    deb_t          q, d;
    logic [CW-1:0] lim;

    always_comb begin
        lim = fast ? CW'(DEB_SHORT) : CW'(DEB_LONG);
        d   = q;
        if (!raw || ignore) begin
            d.cnt = '0;
            d.flg = 1'b0;
        end else if (!q.flg && tick) begin
            if (q.cnt == lim - CW'(1)) begin
                d.flg = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flg;

endmodule

// File: rtl/ffc_mask.sv
module ffc_mask
    import ffc_pkg::*;
(
    input  logic [NUM_CH-1:0]    ss_busy,
    input  logic [NUM_CFGM-1:0]  nomask,
    output logic [NUM_FLAGS-1:0] mask
);
    logic any_ss;
    assign any_ss = |ss_busy;

    // always masked during any soft start
    assign mask[FI_EXT]   = any_ss;
    assign mask[FI_OT1]   = any_ss;
    assign mask[FI_OT2]   = any_ss;
    assign mask[FI_ACS]   = any_ss;
    // fixed per-channel group
    assign mask[FI_REV_A] = ss_busy[0];
    assign mask[FI_UV_A]  = ss_busy[0];
    assign mask[FI_REV_B] = ss_busy[1];
    assign mask[FI_UV_B]  = ss_busy[1];
    // supply overvoltage is never masked
    assign mask[FI_VDD]   = 1'b0;

    // configurable group: bit i drives flag 8+i, channel A/B alternating, C last
    for (genvar i = 0; i < NUM_CFGM; i++) begin : g_cfg
        localparam int CH = (i == NUM_CFGM - 1) ? 2 : (i % 2);
        assign mask[FI_CFG0 + i] = ss_busy[CH] & ~nomask[i];
    end

endmodule

// File: rtl/ffc_restart.sv
module ffc_restart
    import ffc_pkg::*;
#(
    parameter int DLY_BASE = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pson,
    input  logic [NUM_CH-1:0] dis_req,
    input  pol_e              pol_req,
    input  logic [1:0]        dly_sel,
    output logic [NUM_CH-1:0] pwm_off,
    output logic [NUM_CH-1:0] ss_req
);
    localparam int DCW = $clog2(DLY_BASE * 8 + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [NUM_CH-1:0] off;
        pol_e              pol;
        logic [DCW-1:0]    cnt;
        logic [NUM_CH-1:0] ssr;
        logic              pson_q;
    } seq_t;

    seq_t           q, d;
    logic [DCW-1:0] lim;
    logic           fault;
    logic           pson_rise;

    always_comb begin
        lim       = DCW'(DLY_BASE) << dly_sel;
        fault     = |dis_req;
        pson_rise = pson & ~q.pson_q;

        d        = q;
        d.ssr    = '0;
        d.pson_q = pson;

        unique case (q.st)
            ST_RUN: begin
                if (fault) begin
                    d.st  = ST_FAULT;
                    d.off = dis_req;
                    d.pol = pol_req;
                end
            end
            ST_FAULT: begin
                if (fault) begin
                    d.off = q.off | dis_req;
                    d.pol = pol_max(q.pol, pol_req);
                end else begin
                    unique case (q.pol)
                        POL_NOW: begin
                            d.st  = ST_RUN;
                            d.off = '0;
                        end
                        POL_DELAY: begin
                            d.st  = ST_WAIT_DLY;
                            d.cnt = '0;
                        end
                        default: d.st = ST_WAIT_PSON;
                    endcase
                end
            end
            ST_WAIT_DLY: begin
                if (fault) begin
                    d.st  = ST_FAULT;
                    d.off = q.off | dis_req;
                    d.pol = pol_max(q.pol, pol_req);
                end else if (tick) begin
                    if (q.cnt == lim - DCW'(1)) begin
                        d.st  = ST_RUN;
                        d.off = '0;
                        d.ssr = q.off;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + DCW'(1);
                    end
                end
            end
            default: begin
                if (fault) begin
                    d.st  = ST_FAULT;
                    d.off = q.off | dis_req;
                    d.pol = pol_max(q.pol, pol_req);
                end else if (pson_rise) begin
                    d.st  = ST_RUN;
                    d.off = '0;
                    d.ssr = q.off;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_RUN;
            q.pol    <= POL_NOW;
        end else begin
            q <= d;
        end
    end

    assign pwm_off = q.off;
    assign ss_req  = q.ssr;

endmodule

// File: rtl/fault_flag_ctrl.sv
module fault_flag_ctrl
    import ffc_pkg::*;
#(
    parameter int DLY_BASE  = 250000,
    parameter int DEB_LONG  = 500,
    parameter int DEB_SHORT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_us,
    input  logic [NUM_RAW-1:0]   raw_flags,
    input  logic                 vdd_ov_raw,
    input  logic [NUM_CH-1:0]    ss_busy,
    input  logic                 pson,
    input  logic [NUM_CFGM-1:0]  cfg_ss_nomask,
    input  logic [1:0]           cfg_reen_dly,
    input  logic                 cfg_vov_ignore,
    input  logic                 cfg_vov_fast,
    input  logic [1:0]           cfg_ext_action,
    input  logic [1:0]           cfg_ext_after,
    output logic [NUM_FLAGS-1:0] flag_set,
    output logic [NUM_FLAGS-1:0] flag_act,
    output logic [NUM_CH-1:0]    pwm_off,
    output logic [NUM_CH-1:0]    ss_req
);
    typedef struct packed {
        logic [NUM_RAW-1:0] flg;
    } cap_t;

    cap_t                 cap_q, cap_d;
    logic                 vdd_flag;
    logic [NUM_FLAGS-1:0] mask;
    logic [NUM_CH-1:0]    ext_chans;
    logic [NUM_CH-1:0]    dis_req;
    pol_e                 ext_pol;
    pol_e                 pol_req;

    // flag capture
    always_comb begin
        cap_d     = cap_q;
        cap_d.flg = raw_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    ffc_ovp_deb #(
        .DEB_LONG  (DEB_LONG),
        .DEB_SHORT (DEB_SHORT)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_us),
        .raw    (vdd_ov_raw),
        .ignore (cfg_vov_ignore),
        .fast   (cfg_vov_fast),
        .flag   (vdd_flag)
    );

    assign flag_set = {vdd_flag, cap_q.flg};

    ffc_mask u_mask (
        .ss_busy (ss_busy),
        .nomask  (cfg_ss_nomask),
        .mask    (mask)
    );

    assign flag_act = flag_set & ~mask;

    // protective action decode
    always_comb begin
        unique case (cfg_ext_action)
            2'b00:   ext_chans = 3'b000;
            2'b01:   ext_chans = 3'b001;
            2'b10:   ext_chans = 3'b010;
            default: ext_chans = 3'b111;
        endcase
        if (!flag_act[FI_EXT]) ext_chans = '0;

        unique case (cfg_ext_after)
            2'b00:   ext_pol = POL_DELAY;
            2'b01:   ext_pol = POL_NOW;
            default: ext_pol = POL_PSON;
        endcase

        dis_req = ext_chans | {NUM_CH{flag_act[FI_VDD]}};

        if (flag_act[FI_VDD] && (ext_chans != '0)) pol_req = pol_max(POL_DELAY, ext_pol);
        else if (flag_act[FI_VDD])                 pol_req = POL_DELAY;
        else                                       pol_req = ext_pol;
    end

    ffc_restart #(
        .DLY_BASE (DLY_BASE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .pson    (pson),
        .dis_req (dis_req),
        .pol_req (pol_req),
        .dly_sel (cfg_reen_dly),
        .pwm_off (pwm_off),
        .ss_req  (ss_req)
    );

endmodule

// File: rtl/ffc_chk.sv
module ffc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  ss_busy,
    input logic        cfg_vov_ignore,
    input logic [15:0] flag_set,
    input logic [15:0] flag_act,
    input logic [2:0]  pwm_off,
    input logic [2:0]  ss_req
);
    // R3: global group hidden during any soft start
    a_r3_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_busy != 3'b000) |-> (flag_act[3:0] == 4'h0));

    // R8: ignore keeps the supply flag clear
    a_r8_ignore_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vov_ignore |=> !flag_set[15]);

    // R9: active supply flag turns every channel off
    a_r9_vdd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        flag_act[15] |=> (pwm_off == 3'b111));

    // R10: soft-start request is a single-cycle strobe
    a_r10_ssreq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req != 3'b000) |=> (ss_req == 3'b000));

    // R12: a request only restarts channels that were off
    a_r12_ssreq_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_req != 3'b000) |-> ((pwm_off == 3'b000) && (($past(pwm_off) & ss_req) == ss_req)));

endmodule

bind fault_flag_ctrl ffc_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ss_busy        (ss_busy),
    .cfg_vov_ignore (cfg_vov_ignore),
    .flag_set       (flag_set),
    .flag_act       (flag_act),
    .pwm_off        (pwm_off),
    .ss_req         (ss_req)
);

// File: tb/fault_flag_ctrl_test.sv
module fault_flag_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int L_BASE     = 20;
    localparam int D_LONG     = 10;
    localparam int D_SHORT    = 3;
    localparam int NVEC       = 9;

    // {ss_busy, nomask, raw, expected flag_act}
    localparam logic [40:0] VECS [0:NVEC-1] = '{
        {3'b000, 7'h00, 15'h7FFF, 16'h7FFF},
        {3'b001, 7'h00, 15'h7FFF, 16'h6AA0},
        {3'b010, 7'h00, 15'h7FFF, 16'h5550},
        {3'b100, 7'h00, 15'h7FFF, 16'h3FF0},
        {3'b111, 7'h7F, 15'h7FFF, 16'h7F00},
        {3'b111, 7'h00, 15'h7FFF, 16'h0000},
        {3'b001, 7'h7F, 15'h7FFF, 16'h7FA0},
        {3'b000, 7'h00, 15'h0123, 16'h0123},
        {3'b010, 7'h28, 15'h7FFF, 16'h7D50}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b1;
    logic [14:0] raw_flags = '0;
    logic        vdd_ov_raw = 1'b0;
    logic [2:0]  ss_busy = '0;
    logic        pson = 1'b0;
    logic [6:0]  cfg_ss_nomask = '0;
    logic [1:0]  cfg_reen_dly = '0;
    logic        cfg_vov_ignore = 1'b0;
    logic        cfg_vov_fast = 1'b0;
    logic [1:0]  cfg_ext_action = '0;
    logic [1:0]  cfg_ext_after = '0;
    logic [15:0] flag_set;
    logic [15:0] flag_act;
    logic [2:0]  pwm_off;
    logic [2:0]  ss_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_flag_ctrl #(
        .DLY_BASE  (L_BASE),
        .DEB_LONG  (D_LONG),
        .DEB_SHORT (D_SHORT)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_us        (tick_us),
        .raw_flags      (raw_flags),
        .vdd_ov_raw     (vdd_ov_raw),
        .ss_busy        (ss_busy),
        .pson           (pson),
        .cfg_ss_nomask  (cfg_ss_nomask),
        .cfg_reen_dly   (cfg_reen_dly),
        .cfg_vov_ignore (cfg_vov_ignore),
        .cfg_vov_fast   (cfg_vov_fast),
        .cfg_ext_action (cfg_ext_action),
        .cfg_ext_after  (cfg_ext_after),
        .flag_set       (flag_set),
        .flag_act       (flag_act),
        .pwm_off        (pwm_off),
        .ss_req         (ss_req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(3);
        chk("R1 pwm_off", 32'(pwm_off), 0);
        chk("R1 ss_req", 32'(ss_req), 0);
        chk("R1 flag_set", 32'(flag_set), 0);
        rst_n = 1'b1;
        step(1);

        // R2..R5 masking vectors (no action configured)
        for (int v = 0; v < NVEC; v++) begin
            ss_busy       = VECS[v][40:38];
            cfg_ss_nomask = VECS[v][37:31];
            raw_flags     = VECS[v][30:16];
            step(1);
            chk("R2 flag_set", 32'(flag_set), 32'({1'b0, VECS[v][30:16]}));
            chk("R3/R4/R5 flag_act", 32'(flag_act), 32'(VECS[v][15:0]));
        end
        ss_busy = '0; cfg_ss_nomask = '0; raw_flags = '0;
        step(2);

        // R6 action decode with R11 immediate restart
        cfg_ext_after = 2'b01;
        for (int a = 1; a < 4; a++) begin
            cfg_ext_action = 2'(a);
            raw_flags[0] = 1'b1;
            step(2);
            chk("R6 disable", 32'(pwm_off), (a == 1) ? 32'h1 : (a == 2) ? 32'h2 : 32'h7);
            raw_flags[0] = 1'b0;
            step(2);
            chk("R11 immediate", 32'(pwm_off), 0);
            chk("R11 no ss_req", 32'(ss_req), 0);
        end
        cfg_ext_action = 2'b00;
        raw_flags[0] = 1'b1;
        step(4);
        chk("R6 no action", 32'(pwm_off), 0);
        raw_flags[0] = 1'b0;
        step(2);

        // R6 masked external fault during soft start
        cfg_ext_action = 2'b11;
        ss_busy = 3'b100;
        raw_flags[0] = 1'b1;
        step(4);
        chk("R3 masked ext no action", 32'(pwm_off), 0);
        raw_flags[0] = 1'b0;
        ss_busy = '0;
        step(2);

        // R10 delay code 00
        cfg_ext_after = 2'b00;
        cfg_reen_dly = 2'b00;
        raw_flags[0] = 1'b1;
        step(2);
        chk("R6 all off", 32'(pwm_off), 7);
        raw_flags[0] = 1'b0;
        step(L_BASE + 1);
        chk("R10 still off", 32'(pwm_off), 7);
        step(1);
        chk("R10 restored", 32'(pwm_off), 0);
        chk("R10 ss_req", 32'(ss_req), 7);
        step(1);
        chk("R10 ss_req single", 32'(ss_req), 0);

        // R10 delay code 10, channel A only
        cfg_ext_action = 2'b01;
        cfg_reen_dly = 2'b10;
        raw_flags[0] = 1'b1;
        step(2);
        raw_flags[0] = 1'b0;
        step(4 * L_BASE + 1);
        chk("R10 x4 still off", 32'(pwm_off), 1);
        step(1);
        chk("R10 x4 restored", 32'(pwm_off), 0);
        chk("R10 x4 ss_req", 32'(ss_req), 1);
        step(2);

        // R10 tick gating stretches the delay
        cfg_ext_action = 2'b11;
        cfg_reen_dly = 2'b00;
        raw_flags[0] = 1'b1;
        step(2);
        raw_flags[0] = 1'b0;
        step(5);
        tick_us = 1'b0;
        step(50);
        tick_us = 1'b1;
        step(L_BASE - 4);
        chk("R10 gated still off", 32'(pwm_off), 7);
        step(1);
        chk("R10 gated restored", 32'(pwm_off), 0);
        step(2);

        // R13 PSON edge during delay ignored
        raw_flags[0] = 1'b1;
        step(2);
        raw_flags[0] = 1'b0;
        step(3);
        pson = 1'b1;
        step(1);
        pson = 1'b0;
        chk("R13 pson ignored", 32'(pwm_off), 7);
        step(L_BASE - 3);
        chk("R13 still off", 32'(pwm_off), 7);
        step(1);
        chk("R13 normal restore", 32'(pwm_off), 0);
        step(2);

        // R14 new fault aborts delay
        raw_flags[0] = 1'b1;
        step(2);
        raw_flags[0] = 1'b0;
        step(10);
        raw_flags[0] = 1'b1;
        step(2);
        chk("R14 off again", 32'(pwm_off), 7);
        raw_flags[0] = 1'b0;
        step(L_BASE + 1);
        chk("R14 delay restarted", 32'(pwm_off), 7);
        step(1);
        chk("R14 restored", 32'(pwm_off), 0);
        step(2);

        // R12 wait for PSON
        cfg_ext_action = 2'b10;
        cfg_ext_after = 2'b10;
        raw_flags[0] = 1'b1;
        step(2);
        chk("R6 chan B off", 32'(pwm_off), 2);
        raw_flags[0] = 1'b0;
        step(2 + 3 * L_BASE);
        chk("R12 waits", 32'(pwm_off), 2);
        pson = 1'b1;
        step(1);
        chk("R12 pson restore", 32'(pwm_off), 0);
        chk("R12 ss_req", 32'(ss_req), 2);
        pson = 1'b0;
        step(2);
        cfg_ext_action = 2'b00;
        cfg_ext_after = 2'b00;

        // R8 ignore
        cfg_vov_ignore = 1'b1;
        vdd_ov_raw = 1'b1;
        step(30);
        chk("R8 flag clear", 32'(flag_set[15]), 0);
        chk("R8 no shutdown", 32'(pwm_off), 0);

        // R7 long debounce, R9 shutdown and restart
        cfg_vov_ignore = 1'b0;
        step(D_LONG - 1);
        chk("R7 before debounce", 32'(flag_set[15]), 0);
        step(1);
        chk("R7 after debounce", 32'(flag_set[15]), 1);
        chk("R9 not yet off", 32'(pwm_off), 0);
        step(1);
        chk("R9 all off", 32'(pwm_off), 7);
        vdd_ov_raw = 1'b0;
        step(1);
        chk("R7 clears", 32'(flag_set[15]), 0);
        step(L_BASE);
        chk("R9 still off", 32'(pwm_off), 7);
        step(1);
        chk("R9 restored", 32'(pwm_off), 0);
        chk("R9 ss_req", 32'(ss_req), 7);
        step(2);

        // R7 debounce restart on early drop
        vdd_ov_raw = 1'b1;
        step(6);
        vdd_ov_raw = 1'b0;
        step(1);
        vdd_ov_raw = 1'b1;
        step(D_LONG - 1);
        chk("R7 restarted count", 32'(flag_set[15]), 0);
        step(1);
        chk("R7 restarted set", 32'(flag_set[15]), 1);
        vdd_ov_raw = 1'b0;
        step(L_BASE + 4);
        chk("R9 restored 2", 32'(pwm_off), 0);

        // R7 short debounce, R8 ignore drops live flag
        cfg_vov_fast = 1'b1;
        vdd_ov_raw = 1'b1;
        step(D_SHORT - 1);
        chk("R7 short before", 32'(flag_set[15]), 0);
        step(1);
        chk("R7 short set", 32'(flag_set[15]), 1);
        cfg_vov_ignore = 1'b1;
        step(1);
        chk("R8 forced clear", 32'(flag_set[15]), 0);
        vdd_ov_raw = 1'b0;
        cfg_vov_ignore = 1'b0;
        step(L_BASE + 4);
        chk("R9 restored 3", 32'(pwm_off), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule